// File: doc/BRIEF.md
# Grouped Interrupt Expander

This block gathers a large set of peripheral interrupt requests and folds them onto a small number of CPU request lines. With the default parameters it handles 96 sources. They are split into 12 groups of 8, and each group drives one CPU line. Every source has a flag bit that latches when it fires and an enable bit that software controls. Every source also has a vector address of its own, so the CPU learns exactly which source to serve without polling any status.

Each group has an acknowledge bit. Once the CPU takes an interrupt from a group, that bit holds the group's line low until software clears it. A global enable gates every line, and flags keep latching while it is off.

When the CPU acknowledges a line, the block chooses the lowest-numbered source in that group that is both pending and enabled. It presents that source's vector on the next cycle, clears the source's flag and sets the group acknowledge bit, all in the same step.

Top module: `grp_irq_expander`

## Requirements
- R1: After reset, all flags, enables, acknowledge bits and the global enable are 0, `cpu_irq` is all zero and `vec_valid` is 0.
- R2: A source input that is high at a rising clock edge sets that source's flag. Flags of group g read at register address 3+2g, with source i at bit i. Flags latch whatever the global enable and the source enable hold.
- R3: Group g's enable byte is written and read at register address 2+2g, with source i at bit i.
- R4: `cpu_irq[g]` is high exactly when all three hold: the global enable (bit 0 at address 0) is 1, acknowledge bit g is 0, and at least one source in group g has both its flag and its enable set.
- R5: A cycle with `cpu_ack` high, `cpu_ack_line` = g and `cpu_irq[g]` high produces `vec_valid` high for one cycle on the next cycle. In that cycle `vec_addr` = VEC_BASE + (8g+i)*VEC_STEP, where i is the lowest-numbered source of the group that is both pending and enabled.
- R6: That same acknowledge clears the winning flag and sets acknowledge bit g (address 1, bit g). As a result `cpu_irq[g]` drops.
- R7: Writing address 1 clears every acknowledge bit written as 1 and leaves bits written as 0 unchanged. Once its bit is clear, a line with remaining pending and enabled sources is asserted again.
- R8: An acknowledge of a line that is not asserted, or of a line number of 12 or more, produces no vector and changes no flag or acknowledge bit.
- R9: A source pulse in the same cycle that an acknowledge clears that source's flag leaves the flag set.
- R10: A source whose enable bit is 0 never asserts its group line and is never chosen by an acknowledge, but its flag still latches.
- R11: When a CPU acknowledge sets acknowledge bit g in the same cycle that software writes 1 to clear it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from `reg_addr`) |
| irq_src | input | 96 | Peripheral request inputs, source 8g+i is group g, index i |
| cpu_irq | output | 12 | CPU request lines, one per group |
| cpu_ack | input | 1 | CPU acknowledge strobe |
| cpu_ack_line | input | 4 | Line number being acknowledged (0 to 11) |
| vec_valid | output | 1 | Vector address valid |
| vec_addr | output | 22 | Vector address of the winning source |

## Verification
The bench targets several corner cases, and each one shows up clearly when the design gets it wrong:
- Two sources pending in one group. A wrong priority order would send the higher-numbered vector.
- A source that is pending but disabled. A broken enable gate would raise the line, or let that source win the acknowledge.
- A new pulse that lands in the same cycle its flag is cleared. Wrong ordering would lose that request.
- A software clear of the acknowledge bit in the same cycle a CPU acknowledge sets it. Wrong ordering would unmask the line too early.
- Acknowledges of lines that are not asserted or do not exist. Poor guarding would emit a stray vector, or corrupt the flags and acknowledge bits.

// File: rtl/gie_pkg.sv
// Shared definitions for the grouped interrupt expander.
// Assumes the register map: 0 control, 1 acknowledge, then one enable and one
// flag register per group, interleaved.
package gie_pkg;

    localparam int unsigned CTRL_REG = 0;
    localparam int unsigned ACK_REG  = 1;
    localparam int unsigned GRP_REG0 = 2;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CTRL,
        RK_ACK,
        RK_ENA,
        RK_FLAG
    } reg_kind_e;

    // Classify a register address for a block with ngrp groups.
    function automatic reg_kind_e decode_kind(input int unsigned addr, input int unsigned ngrp);
        if (addr == CTRL_REG)
            return RK_CTRL;
        if (addr == ACK_REG)
            return RK_ACK;
        if (addr >= GRP_REG0 + 2 * ngrp)
            return RK_NONE;
        return ((addr - GRP_REG0) % 2 == 0) ? RK_ENA : RK_FLAG;
    endfunction

    // Group number addressed by an enable or flag register.
    function automatic int unsigned decode_grp(input int unsigned addr);
        return (addr - GRP_REG0) / 2;
    endfunction

endpackage

// File: rtl/gie_group.sv
// One interrupt group: per-source flag and enable bits and a lowest-index
// winner selector. Assumes src_in is sampled every cycle (a high level sets
// the flag) and that take is only raised while req is high.
module gie_group #(
    parameter int SRC_PER_GRP = 8,
    localparam int IDX_W = (SRC_PER_GRP > 1) ? $clog2(SRC_PER_GRP) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SRC_PER_GRP-1:0] src_in,
    input  logic                   en_we,
    input  logic [SRC_PER_GRP-1:0] en_wdata,
    input  logic                   take,
    output logic [SRC_PER_GRP-1:0] en_q,
    output logic [SRC_PER_GRP-1:0] flag_q,
    output logic                   req,
    output logic [IDX_W-1:0]       win_idx
);

    logic [SRC_PER_GRP-1:0] pend;
    logic [SRC_PER_GRP-1:0] clr_mask;

    // Enable bits, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_we)
            en_q <= en_wdata;
    end

    // Pick the lowest pending and enabled source.
    always_comb begin
        pend    = flag_q & en_q;
        req     = |pend;
        win_idx = '0;
        for (int i = SRC_PER_GRP - 1; i >= 0; i--) begin
            if (pend[i])
                win_idx = IDX_W'(i);
        end
    end

    // Clear mask for the winner when the group is taken.
    always_comb begin
        clr_mask = '0;
        if (take)
            clr_mask[win_idx] = 1'b1;
    end

    // Flags: a new request wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= '0;
        else
            flag_q <= (flag_q & ~clr_mask) | src_in;
    end

endmodule

// File: rtl/gie_ctrl.sv
// Global enable and per-group acknowledge bits. Assumes ack_set is at most
// one-hot; a set from the CPU side wins over a same-cycle software clear.
module gie_ctrl #(
    parameter int NUM_GRP = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_we,
    input  logic               ctl_wdata,
    input  logic               ack_we,
    input  logic [NUM_GRP-1:0] ack_wdata,
    input  logic [NUM_GRP-1:0] ack_set,
    output logic               glob_en,
    output logic [NUM_GRP-1:0] ack_q
);

    logic [NUM_GRP-1:0] clr_bits;

    // Write-one-to-clear mask from software.
    always_comb begin
        clr_bits = ack_we ? ack_wdata : '0;
    end

    // Global enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            glob_en <= 1'b0;
        else if (ctl_we)
            glob_en <= ctl_wdata;
    end

    // Acknowledge bits: set by CPU takes, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_q <= '0;
        else
            ack_q <= (ack_q & ~clr_bits) | ack_set;
    end

endmodule

// File: rtl/gie_vecgen.sv
// Registered vector address generator: base plus flat source number times
// the vector step. Assumes grp_sel and idx_sel are valid when fire is high.
module gie_vecgen #(
    parameter int          NUM_GRP     = 12,
    parameter int          SRC_PER_GRP = 8,
    parameter int          VEC_W       = 22,
    parameter int unsigned VEC_BASE    = 32'h0000_0D00,
    parameter int unsigned VEC_STEP    = 2,
    localparam int LINE_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int IDX_W  = (SRC_PER_GRP > 1) ? $clog2(SRC_PER_GRP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [LINE_W-1:0] grp_sel,
    input  logic [IDX_W-1:0]  idx_sel,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_addr
);

    logic [31:0] flat_num;

    // Flat source number of the winner.
    always_comb begin
        flat_num = 32'(grp_sel) * 32'(SRC_PER_GRP) + 32'(idx_sel);
    end

    // One-cycle valid strobe and held address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_addr  <= '0;
        end else begin
            vec_valid <= fire;
            if (fire)
                vec_addr <= VEC_W'(VEC_BASE + flat_num * VEC_STEP);
        end
    end

endmodule

// File: rtl/grp_irq_expander.sv
// Top of the grouped interrupt expander. It decodes the register port,
// instantiates one group slice per CPU line, and combines each group's request
// with the global enable and that group's acknowledge bit. A CPU acknowledge
// is honoured only for a line that is asserted in that cycle.
module grp_irq_expander #(
    parameter int          NUM_GRP     = 12,
    parameter int          SRC_PER_GRP = 8,
    parameter int          DATA_W      = 16,
    parameter int          ADDR_W      = 5,
    parameter int          VEC_W       = 22,
    parameter int unsigned VEC_BASE    = 32'h0000_0D00,
    parameter int unsigned VEC_STEP    = 2,
    localparam int NUM_SRC = NUM_GRP * SRC_PER_GRP,
    localparam int LINE_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int IDX_W   = (SRC_PER_GRP > 1) ? $clog2(SRC_PER_GRP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic [NUM_GRP-1:0] cpu_irq,
    input  logic              cpu_ack,
    input  logic [LINE_W-1:0] cpu_ack_line,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_addr
);

    import gie_pkg::*;

    reg_kind_e           kind;
    int unsigned         sel_grp;
    logic [NUM_GRP-1:0]  ena_we;
    logic [NUM_GRP-1:0]  grp_req;
    logic [NUM_GRP-1:0]  grp_take;
    logic [SRC_PER_GRP-1:0] grp_en   [NUM_GRP];
    logic [SRC_PER_GRP-1:0] grp_flag [NUM_GRP];
    logic [IDX_W-1:0]    grp_win  [NUM_GRP];
    logic                glob_en;
    logic [NUM_GRP-1:0]  ack_q;
    logic                fire;
    logic [LINE_W-1:0]   grp_sel;
    logic [IDX_W-1:0]    idx_sel;

    // Register address decode.
    always_comb begin
        kind    = decode_kind(32'(reg_addr), NUM_GRP);
        sel_grp = decode_grp(32'(reg_addr));
        for (int g = 0; g < NUM_GRP; g++)
            ena_we[g] = reg_we && (kind == RK_ENA) && (sel_grp == g);
    end

    // One slice per group.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        gie_group #(
            .SRC_PER_GRP(SRC_PER_GRP)
        ) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_in   (irq_src[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .en_we    (ena_we[g]),
            .en_wdata (reg_wdata[SRC_PER_GRP-1:0]),
            .take     (grp_take[g]),
            .en_q     (grp_en[g]),
            .flag_q   (grp_flag[g]),
            .req      (grp_req[g]),
            .win_idx  (grp_win[g])
        );
    end

    gie_ctrl #(
        .NUM_GRP(NUM_GRP)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (reg_we && (kind == RK_CTRL)),
        .ctl_wdata (reg_wdata[0]),
        .ack_we    (reg_we && (kind == RK_ACK)),
        .ack_wdata (reg_wdata[NUM_GRP-1:0]),
        .ack_set   (grp_take),
        .glob_en   (glob_en),
        .ack_q     (ack_q)
    );

    // CPU lines: global gate, acknowledge gate, group request.
    always_comb begin
        cpu_irq = {NUM_GRP{glob_en}} & ~ack_q & grp_req;
    end

    // Acknowledge steering: only an asserted line is taken.
    always_comb begin
        grp_sel = '0;
        idx_sel = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            grp_take[g] = cpu_ack && (cpu_ack_line == LINE_W'(g)) && cpu_irq[g];
            if (grp_take[g]) begin
                grp_sel = LINE_W'(g);
                idx_sel = grp_win[g];
            end
        end
        fire = |grp_take;
    end

    gie_vecgen #(
        .NUM_GRP     (NUM_GRP),
        .SRC_PER_GRP (SRC_PER_GRP),
        .VEC_W       (VEC_W),
        .VEC_BASE    (VEC_BASE),
        .VEC_STEP    (VEC_STEP)
    ) u_vec (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .grp_sel   (grp_sel),
        .idx_sel   (idx_sel),
        .vec_valid (vec_valid),
        .vec_addr  (vec_addr)
    );

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        case (kind)
            RK_CTRL: reg_rdata = DATA_W'(glob_en);
            RK_ACK:  reg_rdata = DATA_W'(ack_q);
            RK_ENA: begin
                for (int g = 0; g < NUM_GRP; g++)
                    if (sel_grp == g) reg_rdata = DATA_W'(grp_en[g]);
            end
            RK_FLAG: begin
                for (int g = 0; g < NUM_GRP; g++)
                    if (sel_grp == g) reg_rdata = DATA_W'(grp_flag[g]);
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gie_checker.sv
// Protocol checker for the grouped interrupt expander, bound to the top.
// Assumes the control register sits at address 0.
module gie_checker #(
    parameter int          NUM_GRP     = 12,
    parameter int          SRC_PER_GRP = 8,
    parameter int          DATA_W      = 16,
    parameter int          ADDR_W      = 5,
    parameter int          VEC_W       = 22,
    parameter int unsigned VEC_BASE    = 32'h0000_0D00,
    parameter int unsigned VEC_STEP    = 2,
    localparam int LINE_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [NUM_GRP-1:0] cpu_irq,
    input logic              cpu_ack,
    input logic [LINE_W-1:0] cpu_ack_line,
    input logic              vec_valid,
    input logic [VEC_W-1:0]  vec_addr
);

    logic [NUM_GRP-1:0] ack_hit;
    logic               any_hit;

    // Acknowledges that hit an asserted line.
    always_comb begin
        for (int g = 0; g < NUM_GRP; g++)
            ack_hit[g] = cpu_ack && (cpu_ack_line == LINE_W'(g)) && cpu_irq[g];
        any_hit = |ack_hit;
    end

    AST_VEC_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |=> vec_valid); // R5

    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (32'(vec_addr) >= VEC_BASE &&
                       32'(vec_addr) < VEC_BASE + NUM_GRP * SRC_PER_GRP * VEC_STEP)); // R5

    AST_LINE_DROPS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |=> ((cpu_irq & $past(ack_hit)) == '0)); // R6

    AST_NO_STRAY_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |=> !vec_valid); // R8

    AST_GLOBAL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == '0 && !reg_wdata[0]) |=> (cpu_irq == '0)); // R4

endmodule

bind grp_irq_expander gie_checker #(
    .NUM_GRP     (NUM_GRP),
    .SRC_PER_GRP (SRC_PER_GRP),
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .VEC_W       (VEC_W),
    .VEC_BASE    (VEC_BASE),
    .VEC_STEP    (VEC_STEP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .cpu_irq      (cpu_irq),
    .cpu_ack      (cpu_ack),
    .cpu_ack_line (cpu_ack_line),
    .vec_valid    (vec_valid),
    .vec_addr     (vec_addr)
);

// File: tb/grp_irq_expander_bench.sv
// Scoreboard bench: acknowledge tasks push expected vectors, a monitor pops
// and compares them whenever the design presents a vector.
module grp_irq_expander_bench;

    localparam int          NG    = 12;
    localparam int          NS    = 8;
    localparam int unsigned BASE  = 32'h0D00;
    localparam int unsigned STEP  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [95:0] irq_src = '0;
    logic [11:0] cpu_irq;
    logic        cpu_ack = 1'b0;
    logic [3:0]  cpu_ack_line = '0;
    logic        vec_valid;
    logic [21:0] vec_addr;

    int n_chk = 0;
    int n_err = 0;
    logic [21:0] exp_q[$];

    always #2 clk = ~clk;

    grp_irq_expander u_grp_irq_expander (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_src(irq_src),
        .cpu_irq(cpu_irq), .cpu_ack(cpu_ack), .cpu_ack_line(cpu_ack_line),
        .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    function automatic logic [21:0] vec_of(input int g, input int i);
        return 22'(BASE + (g * NS + i) * STEP);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'(addr); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic chk_reg(input string req, input int addr, input logic [15:0] exp);
        reg_addr = 5'(addr);
        #1;
        check(req, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic chk_irq(input string req, input logic [11:0] exp);
        #1;
        check(req, 32'(cpu_irq), 32'(exp));
    endtask

    task automatic pulse(input int g, input int i);
        @(negedge clk);
        irq_src[g*NS+i] = 1'b1;
        @(negedge clk);
        irq_src = '0;
    endtask

    // Driver: acknowledge a line, pushing the expected vector if one is due.
    task automatic ack(input int line, input bit expect_vec, input logic [21:0] exp);
        @(negedge clk);
        cpu_ack = 1'b1; cpu_ack_line = 4'(line);
        if (expect_vec) exp_q.push_back(exp);
        @(negedge clk);
        cpu_ack = 1'b0;
    endtask

    // Monitor: compare each presented vector with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R8: actual=vector %0h expected=no vector", vec_addr);
            end else begin
                check("R5 vector", 32'(vec_addr), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 irq", 32'(cpu_irq), 0);
        check("R1 vec_valid", 32'(vec_valid), 0);
        chk_reg("R1 ctrl", 0, 16'h0);
        chk_reg("R1 ack", 1, 16'h0);
        chk_reg("R1 en g5", 2+2*5, 16'h0);
        chk_reg("R1 flag g0", 3, 16'h0);

        // R2 / R10 flags latch with everything disabled
        pulse(2, 5);
        chk_reg("R2 flag latch", 3+2*2, 16'h0020);
        chk_irq("R10 disabled no irq", 12'h000);

        // R3 enable readback, R4 global off
        wr(2+2*2, 16'h0028);
        chk_reg("R3 enable readback", 2+2*2, 16'h0028);
        chk_irq("R4 global off", 12'h000);
        wr(0, 16'h0001);
        chk_irq("R4 global on", 12'h004);

        // R5 / R6 lowest index wins
        pulse(2, 3);
        chk_reg("R2 two flags", 3+2*2, 16'h0028);
        ack(2, 1'b1, vec_of(2, 3));
        chk_reg("R6 winner cleared", 3+2*2, 16'h0020);
        chk_reg("R6 ack bit set", 1, 16'h0004);
        chk_irq("R6 line drops", 12'h000);

        // R8 ignored acknowledges
        ack(2, 1'b0, '0);
        chk_reg("R8 flags kept", 3+2*2, 16'h0020);
        ack(13, 1'b0, '0);
        chk_reg("R8 ack kept", 1, 16'h0004);

        // R7 write-one-to-clear
        wr(1, 16'h0000);
        chk_reg("R7 zero write", 1, 16'h0004);
        wr(1, 16'h0004);
        chk_reg("R7 cleared", 1, 16'h0000);
        chk_irq("R7 line reasserts", 12'h004);

        // R9 pulse coincides with clear of its flag
        @(negedge clk);
        cpu_ack = 1'b1; cpu_ack_line = 4'd2; irq_src[2*NS+5] = 1'b1;
        exp_q.push_back(vec_of(2, 5));
        @(negedge clk);
        cpu_ack = 1'b0; irq_src = '0;
        chk_reg("R9 flag survives", 3+2*2, 16'h0020);
        wr(1, 16'h0004);
        chk_irq("R9 line back", 12'h004);
        ack(2, 1'b1, vec_of(2, 5));
        wr(1, 16'h0004);
        chk_reg("R6 flags empty", 3+2*2, 16'h0000);
        chk_irq("R4 nothing pending", 12'h000);

        // R10 disabled source not chosen
        wr(2+2*11, 16'h0080);
        pulse(11, 0);
        pulse(11, 7);
        chk_reg("R10 both latch", 3+2*11, 16'h0081);
        ack(11, 1'b1, vec_of(11, 7));
        wr(1, 16'h0800);
        chk_reg("R10 disabled kept", 3+2*11, 16'h0001);
        chk_irq("R10 no request", 12'h000);

        // R11 set wins over same-cycle clear
        wr(2, 16'h0001);
        pulse(0, 0);
        chk_irq("R4 group0", 12'h001);
        @(negedge clk);
        cpu_ack = 1'b1; cpu_ack_line = 4'd0;
        reg_we = 1'b1; reg_addr = 5'd1; reg_wdata = 16'h0001;
        exp_q.push_back(vec_of(0, 0));
        @(negedge clk);
        cpu_ack = 1'b0; reg_we = 1'b0;
        chk_reg("R11 set wins", 1, 16'h0001);

        // R4 global gate with multiple groups
        wr(0, 16'h0000);
        wr(2+2*11, 16'h00FF);
        chk_irq("R4 gated", 12'h000);
        wr(0, 16'h0001);
        chk_irq("R4 g11", 12'h800);
        wr(2+2*7, 16'h0040);
        pulse(7, 6);
        chk_irq("R4 two lines", 12'h880);
        ack(7, 1'b1, vec_of(7, 6));
        chk_irq("R6 only g7 drops", 12'h800);
        ack(11, 1'b1, vec_of(11, 0));
        chk_irq("R6 g11 drops", 12'h000);

        repeat (3) @(negedge clk);
        check("R5 scoreboard drained", 32'(exp_q.size()), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule